// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port with a small register bus. Software programs an output value and a per-pin output enable, and reads the synchronized input levels back. Every pin can also act as an interrupt source. Each pin has a 2-bit trigger code that selects one of four conditions: low level, high level, rising edge or falling edge. A separate per-pin bit can instead select detection on both edges.

Detected events set sticky status bits. Software clears a status bit by writing one to it. A mask register selects which pending bits reach the two interrupt outputs: one output collects pins 0–15 and the other collects pins 16–31. Inputs pass through a two-flop synchronizer before they reach the pad-status register or the detectors. Edges are found by comparing the current synchronized sample with the sample from the previous cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads back zero, `pin_oe` and `pin_out` are zero, and both interrupt outputs are low.
- R2: A write to word offset 0x00 sets `pin_out`, and a write to 0x04 sets `pin_oe` (bit set = pin driven). The next cycle shows the written value. Reading 0x00 returns the written value, not the pad level.
- R3: Offset 0x08 returns `pin_in` delayed by two clock edges through the synchronizer. Writes to it have no effect.
- R4: The trigger code for pin n sits in bits [2*(n mod 16)+1 : 2*(n mod 16)] of offset 0x0C for pins 0–15, or of offset 0x10 for pins 16–31. The codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R5: When bit n of offset 0x1C is 1, pin n flags on both rising and falling edges, and its trigger code is ignored.
- R6: Offset 0x18 holds the status. Writing 1 to a bit clears it, writing 0 leaves it alone, and writing all ones clears every pending bit. Without a clearing write, a set bit stays set.
- R7: Under a level trigger, the status bit is set again on every cycle the level stays active, so a clear only holds after the level has gone away.
- R8: When a detection event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_lo` is high when any of pins 0–15 has both its status bit (0x18) and its mask bit (0x14) set. `irq_hi` does the same for pins 16–31. With the mask at zero, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Output data for the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The assertions check, on every cycle, a set of structural properties:
- the output-data and direction loads;
- the two-edge latency of the pad-status path;
- that status bits stay set when no clearing write is present;
- that a zero mask silences both interrupt outputs;
- that an interrupt output never rises without a pending status bit in its half.

Only the bench scenarios show the trigger decoding itself. They cover each code on pins in both config registers, the both-edge override of a conflicting code, level re-assertion after a clear, and the case where an edge event lands in the same cycle as a clearing write.

// File: rtl/gpio_irq_pkg.sv
// Package: register word indices and trigger codes shared by the GPIO port.
// Assumes a 32-bit register bus with byte addresses on word boundaries.
package gpio_irq_pkg;
    localparam int ADDR_W = 5;
    localparam int WIDX_W = 3;

    localparam logic [WIDX_W-1:0] W_DOUT  = 3'd0;
    localparam logic [WIDX_W-1:0] W_DIR   = 3'd1;
    localparam logic [WIDX_W-1:0] W_PAD   = 3'd2;
    localparam logic [WIDX_W-1:0] W_CFGLO = 3'd3;
    localparam logic [WIDX_W-1:0] W_CFGHI = 3'd4;
    localparam logic [WIDX_W-1:0] W_MASK  = 3'd5;
    localparam logic [WIDX_W-1:0] W_STAT  = 3'd6;
    localparam logic [WIDX_W-1:0] W_BOTH  = 3'd7;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is promised across bits.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the sample one stage deeper each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
// Per-pin trigger detector: decodes the 2-bit trigger code or the both-edge
// override into a one-cycle event. Assumes 'smp' is already synchronized.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   smp,
    input  logic [2*N-1:0] code,
    input  logic [N-1:0]   both,
    output logic [N-1:0]   evt
);
    logic [N-1:0] prev_q;

    // Purpose: remember last cycle's sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp;
    end

    generate
        for (genvar n = 0; n < N; n++) begin : g_pin
            trig_e kind;
            assign kind = trig_e'(code[2*n +: 2]);
            // Purpose: pick the condition this pin is armed for.
            always_comb begin
                if (both[n]) evt[n] = smp[n] ^ prev_q[n];
                else begin
                    unique case (kind)
                        TRIG_LOW:  evt[n] = ~smp[n];
                        TRIG_HIGH: evt[n] = smp[n];
                        TRIG_RISE: evt[n] = smp[n] & ~prev_q[n];
                        TRIG_FALL: evt[n] = ~smp[n] & prev_q[n];
                        default:   evt[n] = 1'b0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_status.sv
// Sticky status with write-one-to-clear and two masked interrupt outputs.
// Assumes a set event and a clear on the same bit resolve to set.
module gpio_irq_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat_q,
    output logic         irq_lo,
    output logic         irq_hi
);
    localparam int HALF = N / 2;

    // Purpose: latch events, drop bits written with one unless re-detected.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    logic [N-1:0] pend;
    assign pend   = stat_q & mask;
    assign irq_lo = |pend[HALF-1:0];
    assign irq_hi = |pend[N-1:HALF];
endmodule

// File: rtl/gpio_irq_port.sv
// GPIO port top: register file, read mux, synchronizer, trigger detection
// and interrupt status. Assumes single-cycle writes and a combinational read.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS      = 32,
    parameter int SYNC_DPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [WIDX_W-1:0] widx;
    logic [PINS-1:0]   dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q;
    logic [PINS-1:0]   pad_q, evt, clr, stat_q;
    logic              bus_addr_unused;

    assign widx            = bus_addr[ADDR_W-1:2];
    assign bus_addr_unused = ^bus_addr[1:0];

    // Purpose: load the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0; dir_q <= '0; cfg_lo_q <= '0;
            cfg_hi_q <= '0; mask_q <= '0; both_q <= '0;
        end else if (bus_we) begin
            case (widx)
                W_DOUT:  dout_q   <= bus_wdata;
                W_DIR:   dir_q    <= bus_wdata;
                W_CFGLO: cfg_lo_q <= bus_wdata;
                W_CFGHI: cfg_hi_q <= bus_wdata;
                W_MASK:  mask_q   <= bus_wdata;
                W_BOTH:  both_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Purpose: form the write-one-to-clear vector for the status register.
    always_comb begin
        clr = '0;
        if (bus_we && widx == W_STAT) clr = bus_wdata;
    end

    // Purpose: select the register addressed by the bus.
    always_comb begin
        unique case (widx)
            W_DOUT:  bus_rdata = dout_q;
            W_DIR:   bus_rdata = dir_q;
            W_PAD:   bus_rdata = pad_q;
            W_CFGLO: bus_rdata = cfg_lo_q;
            W_CFGHI: bus_rdata = cfg_hi_q;
            W_MASK:  bus_rdata = mask_q;
            W_STAT:  bus_rdata = stat_q;
            W_BOTH:  bus_rdata = both_q;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    gpio_sync #(.W(PINS), .STAGES(SYNC_DPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_q)
    );

    gpio_trig_detect #(.N(PINS)) det_i (
        .clk(clk), .rst_n(rst_n), .smp(pad_q),
        .code({cfg_hi_q, cfg_lo_q}), .both(both_q), .evt(evt)
    );

    gpio_irq_status #(.N(PINS)) stat_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .mask(mask_q),
        .stat_q(stat_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Checker for gpio_irq_port, attached by bind. Assumes 32 pins.
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       pin_in,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [31:0]       pad_q,
    input logic [31:0]       stat_q
);
    logic [1:0]        up;
    logic [WIDX_W-1:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    // Purpose: count clock edges since reset, saturating, to guard $past.
    always_ff @(posedge clk) begin
        if (!rst_n)       up <= 2'd0;
        else if (up != 3) up <= up + 2'd1;
    end

    AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (up >= 1 && $past(bus_we && widx == W_DOUT)) |-> pin_out == $past(bus_wdata)); // R2
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (up >= 1 && $past(bus_we && widx == W_DIR)) |-> pin_oe == $past(bus_wdata)); // R2
    AST_PAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (up >= 2) |-> pad_q == $past(pin_in, 2)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (up >= 1 && $past(!(bus_we && widx == W_STAT))) |-> (stat_q & $past(stat_q)) == $past(stat_q)); // R6
    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up >= 1 && $past(bus_we && widx == W_MASK && bus_wdata == 32'd0)) |-> (!irq_lo && !irq_hi)); // R9
    AST_IRQ_LO_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> stat_q[15:0] != 16'd0); // R9
    AST_IRQ_HI_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> stat_q[31:16] != 16'd0); // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .pad_q(pad_q), .stat_q(stat_q)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/100ps
module gpio_irq_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_lo, irq_hi;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
        A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18, A_BOTH = 5'h1C;

    always #2.5 clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), d);
            check("R1 reg zero in reset", d, 32'd0);
        end
        check("R1 oe/out", pin_oe | pin_out, 32'd0);
        check("R1 irq", {30'd0, irq_hi, irq_lo}, 32'd0);
    endtask

    task automatic t_dout_dir();
        logic [31:0] d;
        pins(32'h0F0F_0F0F);
        wr(A_DOUT, 32'hA5A5_1234);
        wr(A_DIR, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_1234);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(A_DOUT, d);
        check("R2 dout readback not pad", d, 32'hA5A5_1234);
    endtask

    task automatic t_pad();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 32'h1357_9BDF;
        @(negedge clk);
        rd(A_PAD, d);
        check("R3 pad not yet after one edge", d, 32'h0F0F_0F0F);
        @(negedge clk);
        rd(A_PAD, d);
        check("R3 pad after two edges", d, 32'h1357_9BDF);
        wr(A_PAD, 32'h0);
        rd(A_PAD, d);
        check("R3 pad write ignored", d, 32'h1357_9BDF);
        pins(32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d);
        check("R6 all-ones clears all", d, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        // pin 3 rising: low cfg bits [7:6] = 2
        wr(A_CLO, 32'h0000_0080);
        wr(A_BOTH, 32'hFFFF_FFF7);
        wr(A_STAT, 32'hFFFF_FFFF);
        pins(32'h0000_0008);
        rd(A_STAT, d);
        check("R4 rising pin3", d, 32'h0000_0008);
        wr(A_STAT, 32'h8);
        pins(32'h0);
        rd(A_STAT, d);
        check("R4 rising ignores fall", d, 32'h0);
        // pin 20 falling: high cfg bits [9:8] = 3
        wr(A_CHI, 32'h0000_0300);
        pins(32'h0010_0000);
        wr(A_BOTH, 32'hFFEF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        pins(32'h0);
        rd(A_STAT, d);
        check("R4 falling pin20", d, 32'h0010_0000);
        wr(A_STAT, 32'h0010_0000);
        pins(32'h0010_0000);
        rd(A_STAT, d);
        check("R4 falling ignores rise", d, 32'h0);
        pins(32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        // pin 17 high level: high cfg bits [3:2] = 1 (keep pin20 code)
        wr(A_CHI, 32'h0000_0304);
        wr(A_BOTH, 32'hFFFD_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d);
        check("R4 high level idle while low", d, 32'h0);
        pins(32'h0002_0000);
        wr(A_STAT, 32'h0002_0000);
        rd(A_STAT, d);
        check("R7 level re-sets after clear", d, 32'h0002_0000);
        pins(32'h0);
        wr(A_STAT, 32'h0002_0000);
        rd(A_STAT, d);
        check("R7 clear holds once level gone", d, 32'h0);
        // pin 5 low level, code 0
        wr(A_BOTH, 32'hFFFF_FFDF);
        @(negedge clk);
        rd(A_STAT, d);
        check("R4 low level pin5", d, 32'h0000_0020);
        wr(A_BOTH, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_both();
        logic [31:0] d;
        // pin 9 code high level (low cfg [19:18]=1), but both-edge set
        wr(A_CLO, 32'h0004_0080);
        pins(32'h0000_0200);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d);
        check("R5 code ignored while static high", d, 32'h0);
        pins(32'h0);
        rd(A_STAT, d);
        check("R5 fall flagged", d, 32'h0000_0200);
        wr(A_STAT, 32'h200);
        pins(32'h0000_0200);
        rd(A_STAT, d);
        check("R5 rise flagged", d, 32'h0000_0200);
    endtask

    task automatic t_w1c_irq();
        logic [31:0] d;
        // pin 20 edge-both in this step: drop it to set status bit 20
        pins(32'h0010_0200);
        pins(32'h0000_0200);
        rd(A_STAT, d);
        check("R6 two bits pending", d, 32'h0010_0200);
        wr(A_MASK, 32'h0);
        check("R9 mask zero both low", {30'd0, irq_hi, irq_lo}, 32'd0);
        wr(A_MASK, 32'h0000_0200);
        check("R9 low half only", {30'd0, irq_hi, irq_lo}, 32'd1);
        wr(A_MASK, 32'h0010_0000);
        check("R9 high half only", {30'd0, irq_hi, irq_lo}, 32'd2);
        wr(A_STAT, 32'h0000_0200);
        rd(A_STAT, d);
        check("R6 w1c leaves zero-written bit", d, 32'h0010_0000);
        wr(A_STAT, 32'h0010_0000);
        check("R9 irq drops after clear", {30'd0, irq_hi, irq_lo}, 32'd0);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        // pin 9 both-edge; toggle so the event lands with the clear
        @(negedge clk);
        pin_in = 32'h0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_STAT; bus_we = 1'b1; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_STAT, d);
        check("R8 event beats clear", d, 32'h0000_0200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        wr(A_BOTH, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        t_dout_dir();
        t_pad();
        t_edges();
        t_levels();
        t_both();
        t_w1c_irq();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule